// File: doc/BRIEF.md
# Fixed-Width Radix-4 Booth Multiplier with Probabilistic Bias

This block multiplies two L-bit two's complement operands and returns an L-bit result that approximates the upper half of the exact 2L-bit product. The multiplier operand is recoded into radix-4 digits in the range -2 to +2, which gives L/2 partial product rows. Only the L most significant columns of the partial product array are built. The discarded low half is replaced by a bias term computed in closed form, so the result stays close to the true high half while the array costs roughly half as much as a full one.

The bias has two parts. The first is a constant count of carries derived from the operand width. The second is a carry-save reduction over a rounding bit and the bits of the highest discarded column, taken as counted carries. Use the block wherever a datapath keeps only the upper word of a product, such as transforms or filters with fixed word length. It accepts one operand pair per cycle and returns the result one cycle later.

Top module: `fixw_booth_mul`

## Requirements
- R1: The multiplier operand is recoded with a zero bit appended below its LSB. For each row i, the triplet (y[2i+1], y[2i], y[2i-1]) maps to a digit as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. There are L/2 rows, and row i carries weight 4^i.
- R2: Each row is L+1 bits wide and holds the digit times X, written in one's complement form for negative digits. Digit +1 gives sign-extended X. Digit -1 gives sign-extended ~X. Digit +2 gives X followed by a 0. Digit -2 gives ~X followed by a 1. Digit 0 gives zero. The +1 correction for a negative row lands in column 2i, which lies in the discarded half.
- R3: Every row is sign-extended and only columns L to 2L-1 are summed. The output is bits [2L-1:L] of (main part + sigma·2^L), wrapping modulo 2^L.
- R4: The constants are fixed by the width. A is floor(3L/32). B is 1 exactly when (3L mod 32) ≥ 16. This gives A=0, B=1 for L=8 and A=1, B=1 for L=16.
- R5: sigma = A + ceil((B + number of ones in column L-1)/2). Column L-1 holds bit L-1-2i of each row i.
- R6: When the multiplier operand is zero, the output is exactly A+B, whatever the other operand.
- R7: For every operand pair, |X·Y − P·2^L| < (L/2 + A + 2)·2^L, where P is the output read as signed.
- R8: out_vld equals in_vld one cycle earlier. A result accepted at an edge appears at the next edge.
- R9: While in_vld is low, prod_hi holds its value.
- R10: A synchronous active-high reset clears out_vld and prod_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair present |
| opnd_x | input | L | Multiplicand, two's complement |
| opnd_y | input | L | Multiplier (recoded), two's complement |
| out_vld | output | 1 | Result present |
| prod_hi | output | L | Approximate upper half of the product |

## Verification
The 8-bit instance is driven with every operand pair, back to back, and each result is compared against an independent model of the truncated array.

- **Negative digits:** a design that mishandles the digit -2 or the row sign extension shows up on the most negative operands.
- **Column selection:** a wrong column choice for the bias shifts results by one unit in the last place for about half of the inputs.
- **Carry tree:** dropping the leftover sum bit of the tree makes results come out low whenever the count of column ones plus B is odd.
- **Zero multiplier:** this case isolates the bias constants, and a wrong A or B shows up as a wrong constant output.

A 16-bit instance is also run on random pairs and extreme values to catch the second carry constant. Hold, latency and reset checks catch a register that loads on every cycle or a valid flag that is not delayed.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [2:0] {DG_ZERO, DG_P1, DG_M1, DG_P2, DG_M2} bdig_e;

  // radix-4 recoding of one overlapping bit triplet
  function automatic bdig_e booth_decode(input logic [2:0] trip);
    case (trip)
      3'b001, 3'b010: return DG_P1;
      3'b011:         return DG_P2;
      3'b100:         return DG_M2;
      3'b101, 3'b110: return DG_M1;
      default:        return DG_ZERO;
    endcase
  endfunction

  // integer part of 3w/32: constant estimation carries
  function automatic int bias_int(input int w);
    return (3 * w) / 32;
  endfunction

  // rounding bit from the fraction of 3w/32
  function automatic int bias_half(input int w);
    return (((3 * w) % 32) >= 16) ? 1 : 0;
  endfunction

  // number of tree carries for the major truncated column
  function automatic int tree_carries(input int w);
    return ((w / 2) + 1) / 2;
  endfunction

  function automatic int sig_width(input int w);
    return $clog2(bias_int(w) + tree_carries(w) + 2);
  endfunction

endpackage

// File: rtl/fwb_pp_row.sv
module fwb_pp_row
  import fwb_pkg::*;
#(
  parameter int L = 8
) (
  input  logic [L-1:0] x_i,
  input  logic [2:0]   trip_i,
  output logic [L:0]   row_o
);
  bdig_e dig;

  assign dig = booth_decode(trip_i);

  always_comb begin
    case (dig)
      DG_P1:   row_o = {x_i[L-1], x_i};
      DG_M1:   row_o = ~{x_i[L-1], x_i};
      DG_P2:   row_o = {x_i, 1'b0};
      DG_M2:   row_o = {~x_i, 1'b1};
      default: row_o = '0;
    endcase
  end
endmodule

// File: rtl/fwb_bias.sv
module fwb_bias
  import fwb_pkg::*;
#(
  parameter int L  = 8,
  parameter int SW = 2
) (
  input  logic [L/2-1:0] mj_col_i,
  output logic [SW-1:0]  sigma_o
);
  localparam int Q       = L / 2;
  localparam int NEC     = tree_carries(L);
  localparam int A_CNT   = bias_int(L);
  localparam logic B_BIT = 1'(bias_half(L));

  logic [2*NEC-1:0] mjp;
  logic [NEC-1:0]   est_carry;
  logic             s_run;
  logic [SW-1:0]    cnt;

  assign mjp = (2*NEC)'(mj_col_i);

  // carry-save chain: each stage folds two column bits into the running sum
  always_comb begin
    s_run = B_BIT;
    for (int k = 0; k < NEC; k++) begin
      if (2*k + 1 < Q) begin
        est_carry[k] = (s_run & mjp[2*k]) | (s_run & mjp[2*k+1]) | (mjp[2*k] & mjp[2*k+1]);
        s_run        = s_run ^ mjp[2*k] ^ mjp[2*k+1];
      end else begin
        est_carry[k] = s_run & mjp[2*k];
        s_run        = s_run ^ mjp[2*k];
      end
    end
  end

  // every carry and the final sum bit enter column L with unit weight
  always_comb begin
    cnt = SW'(A_CNT) + SW'(s_run);
    for (int k = 0; k < NEC; k++) cnt = cnt + SW'(est_carry[k]);
  end

  assign sigma_o = cnt;
endmodule

// File: rtl/fwb_main_acc.sv
module fwb_main_acc #(
  parameter int L  = 8,
  parameter int SW = 2
) (
  input  logic [L/2-1:0][L:0] rows_i,
  input  logic [SW-1:0]       sigma_i,
  output logic [L-1:0]        sum_o
);
  logic signed [2*L:0] ext;
  logic signed [2*L:0] shf;
  logic [L-1:0]        acc;

  // keep only columns L..2L-1 of each sign-extended, shifted row
  always_comb begin
    acc = '0;
    ext = '0;
    shf = '0;
    for (int i = 0; i < L/2; i++) begin
      ext = {{L{rows_i[i][L]}}, rows_i[i]};
      shf = (ext <<< (2*i)) >>> L;
      acc = acc + shf[L-1:0];
    end
    sum_o = acc + L'(sigma_i);
  end
endmodule

// File: rtl/fixw_booth_mul.sv
module fixw_booth_mul
  import fwb_pkg::*;
#(
  parameter int L = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [L-1:0] opnd_x,
  input  logic [L-1:0] opnd_y,
  output logic         out_vld,
  output logic [L-1:0] prod_hi
);
  localparam int Q  = L / 2;
  localparam int SW = sig_width(L);

  logic [L:0]        ypad;
  logic [Q-1:0][L:0] rows;
  logic [Q-1:0]      mj_col;
  logic [SW-1:0]     sigma;
  logic [L-1:0]      prod_nxt;

  assign ypad = {opnd_y, 1'b0};

  for (genvar i = 0; i < Q; i++) begin : g_row
    fwb_pp_row #(.L(L)) row_i (
      .x_i   (opnd_x),
      .trip_i(ypad[2*i+2:2*i]),
      .row_o (rows[i])
    );
    // highest truncated column: bit L-1-2i of row i
    assign mj_col[i] = rows[i][L-1-2*i];
  end

  fwb_bias #(.L(L), .SW(SW)) bias_i (
    .mj_col_i(mj_col),
    .sigma_o (sigma)
  );

  fwb_main_acc #(.L(L), .SW(SW)) acc_i (
    .rows_i (rows),
    .sigma_i(sigma),
    .sum_o  (prod_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      prod_hi <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) prod_hi <= prod_nxt;
    end
  end
endmodule

// File: rtl/fwb_mul_chk.sv
module fwb_mul_chk
  import fwb_pkg::*;
#(
  parameter int L = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_vld,
  input logic [L-1:0]            opnd_y,
  input logic                    out_vld,
  input logic [L-1:0]            prod_hi,
  input logic [L/2-1:0]          mj_col,
  input logic [sig_width(L)-1:0] sigma
);
  localparam int SW      = sig_width(L);
  localparam int A_CNT   = bias_int(L);
  localparam int B_INT   = bias_half(L);
  localparam logic B_BIT = 1'(B_INT);

  AST_BIAS_EQ: assert property (@(posedge clk) disable iff (rst)
    sigma == SW'(A_CNT + (($countones({B_BIT, mj_col}) + 1) / 2))); // R5

  AST_ZERO_MULT: assert property (@(posedge clk) disable iff (rst)
    (in_vld && opnd_y == '0) |=> prod_hi == L'(A_CNT + B_INT)); // R6

  AST_VLD_SET: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R8

  AST_VLD_CLR: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R8

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(prod_hi)); // R9

  AST_RST_CLR: assert property (@(posedge clk)
    rst |=> (!out_vld && prod_hi == '0)); // R10
endmodule

bind fixw_booth_mul fwb_mul_chk #(.L(L)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .in_vld (in_vld),
  .opnd_y (opnd_y),
  .out_vld(out_vld),
  .prod_hi(prod_hi),
  .mj_col (mj_col),
  .sigma  (sigma)
);

// File: tb/fixw_booth_mul_tb_top.sv
module fixw_booth_mul_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v8 = 1'b0, v16 = 1'b0;
  logic [7:0]  x8 = '0, y8 = '0, o8;
  logic [15:0] x16 = '0, y16 = '0, o16;
  logic ov8, ov16;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  fixw_booth_mul #(.L(8)) dut_i (
    .clk(clk), .rst(rst), .in_vld(v8), .opnd_x(x8), .opnd_y(y8),
    .out_vld(ov8), .prod_hi(o8)
  );

  fixw_booth_mul #(.L(16)) dut16_i (
    .clk(clk), .rst(rst), .in_vld(v16), .opnd_x(x16), .opnd_y(y16),
    .out_vld(ov16), .prod_hi(o16)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ybit(input longint v, input int k);
    if (k < 0) return 0;
    return (v >>> k) & 1;
  endfunction

  // arithmetic restatement of the truncated array (R1..R5)
  function automatic longint ref_out(input longint x, input longint y, input int w);
    longint mp = 0, pop = 0, a, b, d, pp, t, sig;
    for (int i = 0; i < w/2; i++) begin
      d   = -2*ybit(y, 2*i+1) + ybit(y, 2*i) + ybit(y, 2*i-1);
      pp  = d * x - ((d < 0) ? 1 : 0);
      t   = pp <<< (2*i);
      mp  = mp + (t >>> w);
      pop = pop + ((t >>> (w-1)) & 1);
    end
    a   = (3*w) / 32;
    b   = (((3*w) % 32) >= 16) ? 1 : 0;
    sig = a + (b + pop + 1) / 2;
    return (mp + sig) & ((64'sd1 <<< w) - 1);
  endfunction

  function automatic longint sx(input longint v, input int w);
    return (v >= (64'sd1 <<< (w-1))) ? v - (64'sd1 <<< w) : v;
  endfunction

  function automatic bit in_bound(input longint x, input longint y, input longint p, input int w);
    longint err = x*y - sx(p, w) * (64'sd1 <<< w);
    longint lim = (w/2 + (3*w)/32 + 2) * (64'sd1 <<< w);
    if (err < 0) err = -err;
    return err < lim;
  endfunction

  task automatic t_reset;
    v8 = 1'b1; x8 = 8'h5a; y8 = 8'h33;
    v16 = 1'b1; x16 = 16'h1234; y16 = 16'h7777;
    repeat (3) @(negedge clk);
    chk(ov8 == 1'b0 && o8 == '0, "R10 reset L8", {ov8, o8}, 0);
    chk(ov16 == 1'b0 && o16 == '0, "R10 reset L16", {ov16, o16}, 0);
    v8 = 1'b0; v16 = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_exhaustive8;
    longint ex = 0, xp = 0, yp = 0;
    bit pend = 0;
    for (int xi = 0; xi < 256; xi++) begin
      for (int yi = 0; yi < 256; yi++) begin
        @(negedge clk);
        if (pend) begin
          chk(o8 == 8'(ex), "R1 R2 R3 R5 exhaustive L8", o8, ex);
          chk(in_bound(xp, yp, o8, 8), "R7 bound L8", o8, ex);
        end
        x8 = 8'(xi); y8 = 8'(yi); v8 = 1'b1;
        xp = sx(xi, 8); yp = sx(yi, 8);
        ex = ref_out(xp, yp, 8);
        pend = 1;
      end
    end
    @(negedge clk);
    chk(o8 == 8'(ex) && ov8, "R3 last L8", o8, ex);
    v8 = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b, input string tag);
    longint ex;
    @(negedge clk);
    x16 = a; y16 = b; v16 = 1'b1;
    ex = ref_out(sx(a, 16), sx(b, 16), 16);
    @(negedge clk);
    v16 = 1'b0;
    chk(o16 == 16'(ex), tag, o16, ex);
    chk(in_bound(sx(a, 16), sx(b, 16), o16, 16), "R7 bound L16", o16, ex);
  endtask

  task automatic t_random16;
    drive16(16'h8000, 16'h8000, "R2 R3 min*min L16");
    drive16(16'h7fff, 16'h8000, "R2 R3 max*min L16");
    drive16(16'h7fff, 16'h7fff, "R3 max*max L16");
    drive16(16'hffff, 16'h5555, "R1 digits L16");
    drive16(16'h0001, 16'haaaa, "R1 digits L16");
    for (int n = 0; n < 3000; n++)
      drive16(16'($urandom), 16'($urandom), "R1 R2 R3 R5 random L16");
  endtask

  task automatic t_zero_mult;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      x8 = 8'(n * 77 + 128); y8 = '0; v8 = 1'b1;
      x16 = 16'(n * 20011 + 32768); y16 = '0; v16 = 1'b1;
      @(negedge clk);
      v8 = 1'b0; v16 = 1'b0;
      chk(o8 == 8'd1, "R6 R4 zero multiplier L8", o8, 1);
      chk(o16 == 16'd2, "R6 R4 zero multiplier L16", o16, 2);
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    x8 = 8'h7f; y8 = 8'h81; v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    chk(ov8 == 1'b1, "R8 valid after one cycle", ov8, 1);
    chk(o8 == 8'(ref_out(127, -127, 8)), "R8 data after one cycle", o8, ref_out(127, -127, 8));
    @(negedge clk);
    chk(ov8 == 1'b0, "R8 valid drops", ov8, 0);
  endtask

  task automatic t_hold;
    logic [7:0] keep;
    @(negedge clk);
    x8 = 8'h93; y8 = 8'h6c; v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    keep = o8;
    for (int n = 0; n < 3; n++) begin
      x8 = 8'(n * 51 + 7); y8 = 8'(n * 29 + 100);
      @(negedge clk);
      chk(o8 == keep && !ov8, "R9 hold while idle", o8, keep);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_hold();
    t_zero_mult();
    t_exhaustive8();
    t_random16();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule